// File: doc/BRIEF.md
# Address-Range Chip Select Generator

This block turns a 24-bit CPU address into one of four active-low chip-select strobes and decides how long each bus cycle lasts. Every select carries its own small set of configuration registers: a lower page bound, an upper page bound and a control byte. The control byte turns the select on, marks it as a memory or an I/O select, and gives it a count of extra clocks. Memory selects compare the top address byte (the 64 KB page) against their bounds. I/O selects compare the middle address byte and respond only to I/O cycles.

When several selects match, the one with the lowest index wins. An on-chip RAM window, whose page and enable come from the RAM controller, takes precedence over every memory select. A cycle begins on a one-clock start strobe. The decode is registered on that edge and held until the cycle ends. The cycle is then stretched by the programmed wait count and by the external WAIT input, and it ends with a one-clock done pulse.

While an external master owns the bus, the select still decodes, but the cycle is never stretched.

Top module: `addr_csel`

## Requirements
- R1: Configuration writes use `cfg_addr[3:2]` as the select index and `cfg_addr[1:0]` as the register: 0 for the lower bound, 1 for the upper bound, 2 for the control byte. Register code 3 is unused, and writes to it change nothing. Control byte bits: bit 0 enables the select, bit 1 makes it an I/O select (0 makes it a memory select), and bits [4:2] hold the wait count.
- R2: An enabled memory select matches a memory cycle when `cpu_addr[23:16]` lies between its lower and upper bound, both bounds included. Equal bounds cover exactly one 64 KB page.
- R3: When more than one select matches, only the lowest-index one drives its `cs_n` bit low. At most one `cs_n` bit is ever low.
- R4: An I/O select never asserts during a memory cycle, and a memory select never asserts during an I/O cycle.
- R5: On a memory cycle with `ram_win_en` high and `cpu_addr[23:16]` equal to `ram_win_page`, `ram_sel` is asserted and no `cs_n` bit goes low. The cycle then completes one clock after the start edge and ignores `wait_n`.
- R6: A select whose enable bit is 0 never asserts.
- R7: A start is accepted at a clock edge where `cyc_start` is high and no cycle is in progress. `cs_n` and `ram_sel` take the decoded value at that edge and keep it until the cycle ends. With `wait_n` high, `cyc_done` pulses for one clock N+1 edges after the start edge, where N is the winning select's wait count (N is 0 when nothing matches). At the same edge the selects are released.
- R8: Once the wait count has run out, every edge that samples `wait_n` low adds one clock. The wait count runs down while `wait_n` is low. If `wait_n` is low for the first W edges after the start, the cycle ends at edge max(N,W)+1.
- R9: If `busack` is high at the accepted start, the select still decodes, but both the wait count and `wait_n` are ignored. The cycle ends one edge after the start.
- R10: An enabled I/O select matches an I/O cycle when `cpu_addr[15:8]` equals its lower bound. `cpu_addr[23:16]` and the upper bound do not matter.
- R11: While `rst` is high, all `cs_n` bits are high and `ram_sel` and `cyc_done` are low. Any cycle in progress is dropped, and all configuration registers clear to 0, which disables every select.
- R12: A `cyc_start` during a cycle in progress is ignored. A changing `cpu_addr` during that cycle is also ignored: it changes neither the selects nor the end of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Select index [3:2] and register code [1:0] |
| cfg_wdata | input | 8 | Configuration write data |
| ram_win_en | input | 1 | On-chip RAM window enabled |
| ram_win_page | input | 8 | Page (address bits 23:16) of the RAM window |
| cyc_start | input | 1 | One-clock strobe that starts a bus cycle |
| cyc_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| busack | input | 1 | External master owns the bus for this cycle |
| cpu_addr | input | 24 | Cycle address, sampled at the start edge |
| wait_n | input | 1 | Active-low wait request, synchronous to clk |
| cs_n | output | 4 | Active-low chip selects, registered |
| ram_sel | output | 1 | On-chip RAM selected for the current cycle |
| cyc_done | output | 1 | One-clock pulse marking the end of a cycle |

## Verification
The assertions rely on `wait_n`, `cyc_io`, `busack` and `cpu_addr` being synchronous to the clock, and on configuration writes not landing in the middle of a cycle they could affect. Both the registered decode and the hold property depend on this.

The bench drives every input on the falling edge and writes configuration only between cycles. It also changes the address during a cycle only to test that the change is ignored. The random stimulus mixes bounds that overlap, single-page ranges, I/O matches, RAM-window hits, bus-acknowledge cycles and WAIT stretches longer and shorter than the programmed count. Expected selects and latencies come from a reference function in the bench.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int PAGE_W     = 8;
  localparam int WS_W       = 3;
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_IO_BIT = 1;
  localparam int CTL_WS_LSB = 2;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [WS_W-1:0]   ws;
    logic              is_io;
    logic              en;
    logic [PAGE_W-1:0] hi;
    logic [PAGE_W-1:0] lo;
  } cs_cfg_t;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W+1:0]          addr,
  input  logic [PAGE_W-1:0]         wdata,
  output cs_cfg_t [NUM_CS-1:0]      cfg
);
  logic [IDX_W-1:0] wr_idx;
  reg_sel_e         wr_reg;

  assign wr_idx = addr[IDX_W+1:2];
  assign wr_reg = reg_sel_e'(addr[1:0]);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    cs_cfg_t q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && wr_idx == IDX_W'(g)) begin
        case (wr_reg)
          REG_LO:  q.lo <= wdata;
          REG_HI:  q.hi <= wdata;
          REG_CTL: begin
            q.en    <= wdata[CTL_EN_BIT];
            q.is_io <= wdata[CTL_IO_BIT];
            q.ws    <= wdata[CTL_WS_LSB +: WS_W];
          end
          default: ;
        endcase
      end
    end
    assign cfg[g] = q;
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
(
  input  cs_cfg_t           cfg,
  input  logic [PAGE_W-1:0] mem_page,
  input  logic [PAGE_W-1:0] io_page,
  input  logic              io_cyc,
  output logic              hit
);
  logic mem_hit;
  logic io_hit;

  assign mem_hit = !io_cyc && !cfg.is_io && (mem_page >= cfg.lo) && (mem_page <= cfg.hi);
  assign io_hit  = io_cyc && cfg.is_io && (io_page == cfg.lo);
  assign hit     = cfg.en && (mem_hit || io_hit);
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS-1:0] hits,
  output logic [NUM_CS-1:0] grant,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csel_wait.sv
module csel_wait #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            fast,
  input  logic [WS_W-1:0] ws,
  input  logic            wait_n,
  output logic            accept,
  output logic            finish,
  output logic            busy,
  output logic            done
);
  logic [WS_W-1:0] cnt_q;
  logic            fast_q;

  assign accept = start && !busy;
  assign finish = busy && (cnt_q == '0) && (fast_q || wait_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      fast_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        cnt_q  <= fast ? '0 : ws;
        fast_q <= fast;
      end else if (busy) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else if (finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addr_csel.sv
module addr_csel
  import csel_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LOW_W = ADDR_W - 2 * PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              ram_win_en,
  input  logic [PAGE_W-1:0] ram_win_page,
  input  logic              cyc_start,
  input  logic              cyc_io,
  input  logic              busack,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              wait_n,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ram_sel,
  output logic              cyc_done
);
  cs_cfg_t [NUM_CS-1:0] cfg;
  logic [NUM_CS-1:0]    hits;
  logic [NUM_CS-1:0]    grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_any;
  logic [PAGE_W-1:0]    mem_page;
  logic [PAGE_W-1:0]    io_page;
  logic                 ram_hit;
  logic [WS_W-1:0]      sel_ws;
  logic                 accept;
  logic                 finish;
  logic                 busy;
  logic                 unused_low;

  assign mem_page   = cpu_addr[ADDR_W-1 -: PAGE_W];
  assign io_page    = cpu_addr[2*PAGE_W-1 -: PAGE_W];
  assign unused_low = ^cpu_addr[LOW_W-1:0];

  csel_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    csel_match u_match (
      .cfg(cfg[g]), .mem_page(mem_page), .io_page(io_page),
      .io_cyc(cyc_io), .hit(hits[g])
    );
  end

  csel_prio #(.NUM_CS(NUM_CS)) u_prio (
    .hits(hits), .grant(grant), .idx(win_idx), .any(win_any)
  );

  assign ram_hit = !cyc_io && ram_win_en && (mem_page == ram_win_page);
  assign sel_ws  = (win_any && !ram_hit) ? cfg[win_idx].ws : '0;

  csel_wait #(.WS_W(WS_W)) u_wait (
    .clk(clk), .rst(rst), .start(cyc_start), .fast(busack || ram_hit),
    .ws(sel_ws), .wait_n(wait_n), .accept(accept), .finish(finish),
    .busy(busy), .done(cyc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n    <= '1;
      ram_sel <= 1'b0;
    end else if (accept) begin
      cs_n    <= ram_hit ? '1 : ~grant;
      ram_sel <= ram_hit;
    end else if (finish) begin
      cs_n    <= '1;
      ram_sel <= 1'b0;
    end
  end
endmodule

// File: rtl/csel_chk.sv
module csel_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              ram_sel,
  input logic              cyc_done,
  input logic              busy
);
  // R3
  one_cs_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
  // R5
  ram_excl_chk: assert property (@(posedge clk) disable iff (rst) ram_sel |-> (&cs_n));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) cyc_done |=> !cyc_done);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst) cyc_done |-> ((&cs_n) && !ram_sel));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cs_n) && $stable(ram_sel)));
  // R11
  reset_chk: assert property (@(posedge clk) rst |=> ((&cs_n) && !ram_sel && !cyc_done));
endmodule

bind addr_csel csel_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ram_sel(ram_sel),
  .cyc_done(cyc_done), .busy(busy)
);

// File: tb/tb_addr_csel.sv
module tb_addr_csel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ram_win_en = 1'b0;
  logic [7:0]  ram_win_page = '0;
  logic        cyc_start = 1'b0;
  logic        cyc_io = 1'b0;
  logic        busack = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        wait_n = 1'b1;
  logic [3:0]  cs_n;
  logic        ram_sel;
  logic        cyc_done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic [7:0] m_ctl [4];

  always #5 clk = ~clk;

  addr_csel dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ram_win_en(ram_win_en), .ram_win_page(ram_win_page),
    .cyc_start(cyc_start), .cyc_io(cyc_io), .busack(busack),
    .cpu_addr(cpu_addr), .wait_n(wait_n), .cs_n(cs_n), .ram_sel(ram_sel),
    .cyc_done(cyc_done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_ctl[i] = '0;
    end
  endfunction

  // returns {ram, ws[2:0], cs_n[3:0]}
  function automatic logic [7:0] model(input logic [23:0] a, input logic io);
    logic [3:0] c = 4'hF;
    logic [2:0] w = 3'd0;
    logic       r = 1'b0;
    if (!io && ram_win_en && a[23:16] == ram_win_page) r = 1'b1;
    else begin
      for (int i = 0; i < 4; i++) begin
        if (c == 4'hF && m_ctl[i][0] &&
            (io ? (m_ctl[i][1] && a[15:8] == m_lo[i])
                : (!m_ctl[i][1] && a[23:16] >= m_lo[i] && a[23:16] <= m_hi[i]))) begin
          c[i] = 1'b0;
          w = m_ctl[i][4:2];
        end
      end
    end
    return {r, w, c};
  endfunction

  task automatic wr(input int idx, input int r, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 4'(idx * 4 + r);
    cfg_wdata = v;
    if (r == 0) m_lo[idx] = v;
    else if (r == 1) m_hi[idx] = v;
    else if (r == 2) m_ctl[idx] = {3'b000, v[4:0]};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // caller is at a negedge; W = edges after start with wait_n low
  task automatic run(input logic [23:0] a, input logic io, input logic ba,
                     input int W, input bit restrike, input string req);
    logic [7:0] e;
    int lat_exp;
    int lat_got = 0;
    int ws;
    bit moved = 0;
    bit fast;
    e = model(a, io);
    ws = int'(e[6:4]);
    fast = ba || e[7];
    lat_exp = fast ? 1 : (((ws > W) ? ws : W) + 1);
    cpu_addr = a; cyc_io = io; busack = ba; cyc_start = 1'b1; wait_n = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check(req, "cs_n", 32'(cs_n), 32'(e[3:0]));
    check(req, "ram_sel", 32'(ram_sel), 32'(e[7]));
    for (int k = 1; k <= 40; k++) begin
      wait_n = (k <= W) ? 1'b0 : 1'b1;
      if (restrike && k == 2) begin
        cyc_start = 1'b1; cpu_addr = ~a; cyc_io = ~io;
      end else cyc_start = 1'b0;
      @(negedge clk);
      if (cyc_done) begin lat_got = k; break; end
      if (cs_n !== e[3:0] || ram_sel !== e[7]) moved = 1;
    end
    cyc_start = 1'b0; wait_n = 1'b1; busack = 1'b0;
    check("R12", "select hold during cycle", 32'(moved), 32'd0);
    check(fast ? (ba ? "R9" : "R5") : ((W > ws) ? "R8" : "R7"), "latency",
          32'(lat_got), 32'(lat_exp));
    check("R7", "release at done", 32'({ram_sel, cs_n}), 32'h0F);
  endtask

  task automatic program_directed();
    wr(0, 0, 8'h10); wr(0, 1, 8'h1F); wr(0, 2, 8'h09);
    wr(1, 0, 8'h18); wr(1, 1, 8'h30); wr(1, 2, 8'h01);
    wr(2, 0, 8'h40); wr(2, 1, 8'h00); wr(2, 2, 8'h0F);
    wr(3, 0, 8'h80); wr(3, 1, 8'h80); wr(3, 2, 8'h05);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C5A1));
    model_clear();
    repeat (3) @(negedge clk);
    check("R11", "reset outputs", 32'({ram_sel, cyc_done, cs_n}), 32'h0F);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "cleared regs disable all", 32'(model(24'h000000, 1'b0)), 32'h0F);
    run(24'h00_0000, 1'b0, 1'b0, 0, 0, "R11");

    program_directed();
    run(24'h80_1234, 1'b0, 1'b0, 0, 0, "R2");
    run(24'h81_0000, 1'b0, 1'b0, 0, 0, "R2");
    run(24'h7F_FFFF, 1'b0, 1'b0, 0, 0, "R2");
    run(24'h10_0000, 1'b0, 1'b0, 0, 0, "R2");
    run(24'h18_0000, 1'b0, 1'b0, 0, 0, "R3");
    run(24'h1F_FFFF, 1'b0, 1'b0, 0, 0, "R3");
    run(24'h25_0000, 1'b0, 1'b0, 0, 0, "R3");
    run(24'h00_4000, 1'b1, 1'b0, 0, 0, "R4");
    run(24'h00_4000, 1'b0, 1'b0, 0, 0, "R4");
    run(24'h18_0000, 1'b1, 1'b0, 0, 0, "R4");
    run(24'hAB_40CD, 1'b1, 1'b0, 0, 0, "R10");
    check("R10", "upper bound unused for io", 32'(model(24'hFF_4000, 1'b1)), 32'h3B);
    run(24'hFF_4000, 1'b1, 1'b0, 0, 0, "R10");
    ram_win_en = 1'b1; ram_win_page = 8'h18;
    run(24'h18_0005, 1'b0, 1'b0, 4, 0, "R5");
    run(24'h18_4000, 1'b1, 1'b0, 0, 0, "R5");
    ram_win_en = 1'b0;
    run(24'h18_0005, 1'b0, 1'b0, 0, 0, "R5");
    wr(0, 2, 8'h08);
    run(24'h12_0000, 1'b0, 1'b0, 0, 0, "R6");
    run(24'h18_0000, 1'b0, 1'b0, 0, 0, "R6");
    wr(0, 2, 8'h09);
    wr(0, 3, 8'hFF);
    run(24'h18_0000, 1'b0, 1'b0, 0, 0, "R1");
    run(24'h12_0000, 1'b0, 1'b0, 5, 0, "R8");
    run(24'h12_0000, 1'b0, 1'b0, 1, 0, "R8");
    run(24'h42_0000, 1'b0, 1'b0, 3, 0, "R8");
    run(24'h12_0000, 1'b0, 1'b1, 4, 0, "R9");
    run(24'h00_4000, 1'b1, 1'b1, 0, 0, "R9");
    run(24'h00_4000, 1'b1, 1'b0, 0, 1, "R12");
    run(24'h12_0000, 1'b0, 1'b0, 2, 1, "R12");

    // reset in the middle of a cycle
    cpu_addr = 24'h12_0000; cyc_io = 1'b0; cyc_start = 1'b1; wait_n = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R11", "cycle started", 32'(cs_n), 32'hE);
    rst = 1'b1;
    @(negedge clk);
    check("R11", "reset drops cycle", 32'({ram_sel, cyc_done, cs_n}), 32'h0F);
    rst = 1'b0; wait_n = 1'b1;
    model_clear();
    @(negedge clk);
    run(24'h12_0000, 1'b0, 1'b0, 0, 0, "R11");

    // constrained random
    for (int it = 0; it < 240; it++) begin
      if (it % 24 == 0) begin
        for (int s = 0; s < 4; s++) begin
          logic [7:0] lo;
          lo = 8'($urandom_range(0, 200));
          wr(s, 0, lo);
          wr(s, 1, lo + 8'($urandom_range(0, 55)));
          wr(s, 2, 8'($urandom_range(0, 31)));
        end
        ram_win_en = 1'($urandom_range(0, 1));
        ram_win_page = 8'($urandom_range(0, 255));
      end
      begin
        logic [23:0] a;
        logic io;
        io = ($urandom_range(0, 3) == 0);
        a = 24'($urandom);
        if ($urandom_range(0, 1) == 1) begin
          int s;
          s = $urandom_range(0, 3);
          if (io) a[15:8] = m_lo[s];
          else a[23:16] = m_lo[s] + 8'($urandom_range(0, 20));
        end
        run(a, io, ($urandom_range(0, 7) == 0), $urandom_range(0, 9), 0,
            io ? "R4" : "R2");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule